// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits in the clock front end of a PCM audio converter. It counts master-clock cycles across each period of the frame clock (LRCK). It then matches the count against the oversampling ratios allowed in the current speed mode. Downstream logic gets a ratio code, a flag saying the code is trustworthy, and a flag saying the clocks form no legal combination.

A speed-select input picks normal speed (frame rates of roughly 30 to 54 kHz) or double speed (roughly 54 to 108 kHz). Quad speed is never selected. The block samples the speed selection only while the power-down pin is held low, so a new selection needs a reset through that pin. While powered down, and after release until the frame clock shows activity, the block asks the rest of the converter to stay powered down. It does the same if the frame clock stops for too long, and it then starts detection again.

Top module: `mclk_ratio_det`

## Requirements
- R1: After the asynchronous reset, ratio_code is 7, ratio_valid is 0, ratio_err is 0 and pd_req is 1.
- R2: While pdn_n is low, pd_req is 1 and ratio_valid and ratio_err are 0. spd_sel is captured only while pdn_n is low. A change of spd_sel while pdn_n is high has no effect on classification.
- R3: After pdn_n goes high, pd_req stays 1 until the first rising edge of LRCK is seen through the two-flop synchronizer. It then falls.
- R4: The measured period is the number of master-clock cycles between two consecutive synchronized LRCK rising edges.
- R5: With spd_sel captured as 0 (normal speed), the legal ratios are 256, 384, 512, 768 and 1152, reported as codes 2, 3, 4, 5 and 6.
- R6: With spd_sel captured as 1 (double speed), the legal ratios are 128, 192, 256 and 384, reported as codes 0, 1, 2 and 3.
- R7: A period matches a ratio when it lies within 2 cycles of it. A period 3 or more cycles away from every legal ratio matches none.
- R8: ratio_valid rises only after two consecutive periods match the same ratio. A period that matches a different ratio clears ratio_valid until that ratio repeats.
- R9: A period that matches no legal ratio of the captured mode sets ratio_err and clears ratio_valid. The next matching period clears ratio_err.
- R10: If no LRCK rising edge arrives within 2048 master-clock cycles of the previous one, ratio_valid clears and pd_req returns to 1 until LRCK activity resumes.
- R11: ratio_code is 7 whenever ratio_valid is 0. Otherwise it carries the code of the matched ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock; all counting is done in this domain |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down pin, active low; samples spd_sel while low |
| lrck | input | 1 | Frame clock, asynchronous to clk_mst |
| spd_sel | input | 1 | 0 selects normal speed, 1 selects double speed |
| ratio_code | output | 3 | 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1152, 7=unknown |
| ratio_valid | output | 1 | Ratio confirmed by two equal consecutive periods |
| ratio_err | output | 1 | Last period matched no legal ratio |
| pd_req | output | 1 | Request to hold the converter powered down |

## Verification
The frame clock is driven with steady periods that sit on every legal ratio of both modes, with periods offset by up to two cycles, and with periods offset by three cycles. This separates matching from rejection at the tolerance edge. Ratios that are legal in only one mode are applied in the other mode to show that the captured speed bit gates the legal set. Flipping speed-select without a power-down pulse shows that the selection is ignored. A single period of a different ratio shows that one period is not enough to confirm a ratio. Stopping the frame clock after a confirmed ratio exercises the timeout and the return to the power-down request.

// File: rtl/mclk_ratio_det.sv
module mclk_ratio_det #(
  parameter int CNT_W   = 12,
  parameter int TIMEOUT = 2048,
  parameter int TOL     = 2
) (
  input  logic       clk_mst,
  input  logic       rst_n,
  input  logic       pdn_n,
  input  logic       lrck,
  input  logic       spd_sel,
  output logic [2:0] ratio_code,
  output logic       ratio_valid,
  output logic       ratio_err,
  output logic       pd_req
);

  localparam logic [2:0] CODE_UNK = 3'd7;
  localparam int         NUM_RAT  = 7;

  typedef enum logic [1:0] {ST_PD, ST_WAIT, ST_MEAS} st_t;

  st_t              st;
  logic [2:0]       lr_sync;
  logic             mode_q;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       last_code;
  logic             last_ok;
  logic             valid_q;
  logic             err_q;
  logic             hit;
  logic [2:0]       hit_code;

  function automatic int ratio_of(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

  wire lr_rise = lr_sync[1] & ~lr_sync[2];
  wire tout    = (st == ST_MEAS) && (int'(cnt) >= TIMEOUT);

  always_ff @(posedge clk_mst or negedge rst_n)
    if (!rst_n) lr_sync <= '0;
    else        lr_sync <= {lr_sync[1:0], lrck};

  always_comb begin
    hit      = 1'b0;
    hit_code = CODE_UNK;
    for (int i = 0; i < NUM_RAT; i++) begin
      if ((mode_q ? (i <= 3) : (i >= 2)) &&
          int'(cnt) >= ratio_of(i) - TOL && int'(cnt) <= ratio_of(i) + TOL) begin
        hit      = 1'b1;
        hit_code = 3'(i);
      end
    end
  end

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PD;
      mode_q    <= 1'b0;
      cnt       <= '0;
      last_code <= CODE_UNK;
      last_ok   <= 1'b0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else if (!pdn_n) begin
      st        <= ST_PD;
      mode_q    <= spd_sel;
      cnt       <= '0;
      last_code <= CODE_UNK;
      last_ok   <= 1'b0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (st)
        ST_PD:   st <= ST_WAIT;
        ST_WAIT: if (lr_rise) begin
                   st  <= ST_MEAS;
                   cnt <= CNT_W'(1);
                 end
        default: begin
          if (lr_rise) begin
            cnt <= CNT_W'(1);
            if (hit) begin
              err_q     <= 1'b0;
              valid_q   <= last_ok && (last_code == hit_code);
              last_code <= hit_code;
              last_ok   <= 1'b1;
            end else begin
              err_q     <= 1'b1;
              valid_q   <= 1'b0;
              last_ok   <= 1'b0;
            end
          end else if (tout) begin
            st      <= ST_WAIT;
            cnt     <= '0;
            valid_q <= 1'b0;
            last_ok <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign ratio_valid = valid_q;
  assign ratio_err   = err_q;
  assign ratio_code  = valid_q ? last_code : CODE_UNK;
  assign pd_req      = (st != ST_MEAS);

  AST_PD_HOLD: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !pdn_n |=> (pd_req && !ratio_valid && !ratio_err)); // R2

  AST_MODE_STABLE: assert property (@(posedge clk_mst) disable iff (!rst_n)
    pdn_n |=> $stable(mode_q)); // R2

  AST_WAKE_ON_EDGE: assert property (@(posedge clk_mst) disable iff (!rst_n)
    $fell(pd_req) |-> $past(lr_rise)); // R3

  AST_LEGAL_SET: assert property (@(posedge clk_mst) disable iff (!rst_n)
    ratio_valid |-> (mode_q ? (ratio_code <= 3'd3) : (ratio_code >= 3'd2 && ratio_code <= 3'd6))); // R5 R6

  AST_VALID_ERR_EXCL: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !(ratio_valid && ratio_err)); // R9

  AST_TIMEOUT_DROP: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (pdn_n && st == ST_MEAS && !lr_rise && int'(cnt) >= TIMEOUT) |=> (!ratio_valid && pd_req)); // R10

endmodule

// File: tb/sim_mclk_ratio_det.sv
module sim_mclk_ratio_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn_n = 1'b0;
  logic       lrck = 1'b0;
  logic       spd_sel = 1'b0;
  logic [2:0] ratio_code;
  logic       ratio_valid;
  logic       ratio_err;
  logic       pd_req;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  mclk_ratio_det u0 (
    .clk_mst(clk), .rst_n(rst_n), .pdn_n(pdn_n), .lrck(lrck), .spd_sel(spd_sel),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid), .ratio_err(ratio_err), .pd_req(pd_req)
  );

  // speed, period, code, valid, err
  localparam int NV = 14;
  localparam int VEC [NV][5] = '{
    '{0,  256, 2, 1, 0},   // R5
    '{0,  258, 2, 1, 0},   // R7
    '{0,  384, 3, 1, 0},   // R5
    '{0,  510, 4, 1, 0},   // R7
    '{0,  766, 5, 1, 0},   // R7
    '{0,  765, 7, 0, 1},   // R7
    '{0, 1152, 6, 1, 0},   // R5
    '{0,  128, 7, 0, 1},   // R5
    '{1,  128, 0, 1, 0},   // R6
    '{1,  192, 1, 1, 0},   // R6
    '{1,  386, 3, 1, 0},   // R6
    '{1,  126, 0, 1, 0},   // R7
    '{1,  512, 7, 0, 1},   // R6
    '{1,  253, 7, 0, 1}    // R4
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_pd(input logic s);
    @(negedge clk);
    lrck = 1'b0; pdn_n = 1'b0; spd_sel = s;
    repeat (3) @(negedge clk);
    pdn_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drive(int n, int k);
    for (int p = 0; p < k; p++) begin
      lrck = 1'b1;
      repeat (n / 2) @(negedge clk);
      lrck = 1'b0;
      repeat (n - n / 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 code", ratio_code, 7);
    check("R1 valid", ratio_valid, 0);
    check("R1 err", ratio_err, 0);
    check("R1 pd_req", pd_req, 1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_pd(VEC[v][0][0]);
      drive(VEC[v][1], 4);
      check($sformatf("R5/R6 vec%0d code", v), ratio_code, VEC[v][2]);
      check($sformatf("R8 vec%0d valid", v), ratio_valid, VEC[v][3]);
      check($sformatf("R9 vec%0d err", v), ratio_err, VEC[v][4]);
    end

    // R3: power-down request held until first frame edge
    do_pd(1'b0);
    repeat (20) @(negedge clk);
    check("R3 pd_req before edge", pd_req, 1);
    lrck = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 pd_req after edge", pd_req, 0);
    lrck = 1'b0;

    // R8 and R11: one differing period drops valid, a repeat restores it
    do_pd(1'b0);
    drive(256, 4);
    check("R8 confirmed 256", ratio_code, 2);
    drive(384, 1);
    lrck = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 valid after single change", ratio_valid, 0);
    check("R11 code while invalid", ratio_code, 7);
    repeat (187) @(negedge clk);
    lrck = 1'b0;
    repeat (192) @(negedge clk);
    lrck = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 valid after repeat", ratio_valid, 1);
    check("R8 code after repeat", ratio_code, 3);
    lrck = 1'b0;

    // R9: error cleared by a matching period
    do_pd(1'b0);
    drive(600, 3);
    check("R9 err set", ratio_err, 1);
    drive(256, 3);
    check("R9 err cleared", ratio_err, 0);
    check("R9 valid after recovery", ratio_valid, 1);

    // R2: speed-select change without power-down is ignored
    do_pd(1'b0);
    drive(512, 4);
    spd_sel = 1'b1;
    drive(512, 4);
    check("R2 code kept normal mode", ratio_code, 4);
    check("R2 valid kept", ratio_valid, 1);
    check("R2 no err", ratio_err, 0);

    // R10: frame clock stops
    repeat (2100) @(negedge clk);
    check("R10 valid dropped", ratio_valid, 0);
    check("R10 pd_req raised", pd_req, 1);
    check("R11 code unknown", ratio_code, 7);

    // R2: power-down pin low clears results
    drive(512, 4);
    @(negedge clk);
    pdn_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 pd_req in power-down", pd_req, 1);
    check("R2 valid in power-down", ratio_valid, 0);
    pdn_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule